// File: doc/BRIEF.md
# Time Base and Watchdog Interrupt Generator

This block runs directly from a 32.768 kHz clock. It splits one free-running count chain between two users. A divide-by-256 prescaler feeds a binary divider, and a 3-bit rate code picks one divider tap. The picked tap is a square wave between 1 Hz and 128 Hz. A small counter that is two bits deeper counts the periods of that wave. When it wraps, it latches a watchdog timeout flag, so the timeout lasts four periods of the selected rate, from 4 s down to 1/32 s.

The interrupt output models an open-drain, active-low pin. It is a single "pull low" enable. It can carry the time-base square wave or the latched watchdog flag. Single-cycle command strobes come from a command decoder outside the block. They switch the timer output, the watchdog and the interrupt on and off, restart the shared count chain, restart the watchdog, and load a new rate code. Each group of controls acts on its own. The watchdog flag stays latched until the watchdog is cleared or the interrupt is switched off.

Top module: `tbase_wdog`

## Requirements
- R1: After reset, the timer output, the watchdog and the interrupt are all switched off, and the rate code is 0. `irq_pull_low` is 0 and stays 0 until commands arrive.
- R2: Rate code k selects a square wave of 2^k Hz, for k from 0 to 7. With the default parameters, its period is 2^(15-k) clock cycles. It is low for the first half of each period, counted from a chain restart.
- R3: Time-base mode applies when the interrupt is on, the timer output is on and the watchdog is off. In this mode `irq_pull_low` is 1 exactly while the selected square wave is high. Whenever the interrupt is off, `irq_pull_low` is 0.
- R4: A watchdog that is on counts completed periods of the selected rate. At the fourth completed period after it was last cleared, it latches its flag. The flag stays set, whatever the count chain does, until a release.
- R5: A watchdog clear strobe clears the latched flag and restarts the four-period count. An interrupt-off strobe also clears the flag, but it leaves the count alone.
- R6: A timer clear strobe restarts the shared count chain from zero, so the selected wave begins a fresh low half-period. It leaves the flag, the watchdog count and every on/off state unchanged.
- R7: When the interrupt and the watchdog are both on, `irq_pull_low` follows the latched flag alone, even when the timer output is on.
- R8: The timer, watchdog and interrupt on/off controls are independent of each other. Each takes effect on the next cycle. If the on strobe and the off strobe of one control arrive in the same cycle, the off strobe wins.
- R9: While the watchdog is off, its period count holds its value and no flag is latched. Switching it back on resumes the count from where it stopped.
- R10: A new rate code loaded with `rate_wr` takes effect from the next cycle, for both the wave and the watchdog period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through two synchronising flops |
| tmr_on | input | 1 | Strobe: time-base output on |
| tmr_off | input | 1 | Strobe: time-base output off |
| tmr_clr | input | 1 | Strobe: restart the shared count chain |
| wdt_on | input | 1 | Strobe: watchdog on |
| wdt_off | input | 1 | Strobe: watchdog off |
| wdt_clr | input | 1 | Strobe: restart the watchdog count and release the flag |
| irq_on | input | 1 | Strobe: interrupt output on |
| irq_off | input | 1 | Strobe: interrupt output off, releases the flag |
| rate_wr | input | 1 | Strobe: load `rate_code` |
| rate_code | input | CODE_W (3) | Rate code k, selecting a 2^k Hz time base |
| irq_pull_low | output | 1 | 1 = the open-drain interrupt pin is driven low |

## Verification
The bench targets the exact cycle of the watchdog timeout at the fastest rate. A design that is one stage short or long, or that counts a false period on a chain restart, would raise the flag a period early or late. It also applies timer clears when the selected tap is high. A design that found period ends by edge detection would count an extra watchdog period there. Cases where both strobes of one control arrive together, and where the flag is released by an interrupt-off strobe rather than by a watchdog clear, expose a reversed priority and a latch that only one of the two commands releases. A long pseudo-random run of mixed strobes and rate changes, compared cycle by cycle against a behavioural model, catches any coupling between the controls that should be independent.

// File: rtl/tbw_pkg.sv
package tbw_pkg;

  typedef struct packed {
    logic tmr_en;
    logic wdt_en;
    logic irq_en;
  } tbw_en_t;

  function automatic int unsigned tap_index(int unsigned cnt_w, int unsigned tb_w,
                                            int unsigned code);
    int unsigned c;
    c = (code > tb_w) ? tb_w : code;
    return cnt_w - 1 - c;
  endfunction

endpackage

// File: rtl/tbw_divider.sv
module tbw_divider #(
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned TB_W   = 7,
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [CODE_W-1:0] code,
  output logic              wave,
  output logic              tick
);
  localparam int unsigned CNT_W = PRE_W + TB_W;
  localparam int unsigned NCODE = 1 << CODE_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NCODE-1:0] wave_v, tick_v;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < NCODE; g++) begin : g_tap
    localparam int unsigned B = tbw_pkg::tap_index(CNT_W, TB_W, g);
    assign wave_v[g] = cnt_q[B];
    assign tick_v[g] = &cnt_q[B:0];
  end

  assign wave = wave_v[code];
  assign tick = tick_v[code] & ~clr;

  p_clr_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  p_free_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  p_tick_wraps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $stable(code)) |=> !wave);

endmodule

// File: rtl/tbw_watchdog.sv
module tbw_watchdog #(
  parameter int unsigned WDT_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic wdt_en,
  input  logic wdt_clr,
  input  logic flag_clr,
  output logic flag
);
  logic [WDT_W-1:0] stage_q, stage_d;
  logic             flag_q, flag_d;
  logic             adv;

  assign adv = tick & wdt_en;

  always_comb begin
    stage_d = stage_q;
    if (wdt_clr)  stage_d = '0;
    else if (adv) stage_d = stage_q + 1'b1;
  end

  always_comb begin
    flag_d = flag_q;
    if (wdt_clr || flag_clr)  flag_d = 1'b0;
    else if (adv && &stage_q) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      flag_q  <= flag_d;
    end
  end

  assign flag = flag_q;

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !wdt_clr && !flag_clr) |=> flag_q);
  p_flag_needs_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !tick) |=> !flag_q);
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_clr || flag_clr) |=> !flag_q);
  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_en && !wdt_clr) |=> ($stable(stage_q) && !$rose(flag_q)));

endmodule

// File: rtl/tbw_ctrl.sv
module tbw_ctrl #(
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_on,
  input  logic              tmr_off,
  input  logic              wdt_on,
  input  logic              wdt_off,
  input  logic              irq_on,
  input  logic              irq_off,
  input  logic              rate_wr,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              wave,
  input  logic              flag,
  output logic              wdt_en,
  output logic [CODE_W-1:0] rate,
  output logic              irq_pull_low
);
  import tbw_pkg::*;

  tbw_en_t           en_q, en_d;
  logic [CODE_W-1:0] rate_q, rate_d;

  always_comb begin
    en_d = en_q;
    if (tmr_off)     en_d.tmr_en = 1'b0;
    else if (tmr_on) en_d.tmr_en = 1'b1;
    if (wdt_off)     en_d.wdt_en = 1'b0;
    else if (wdt_on) en_d.wdt_en = 1'b1;
    if (irq_off)     en_d.irq_en = 1'b0;
    else if (irq_on) en_d.irq_en = 1'b1;
    rate_d = rate_wr ? rate_code : rate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      rate_q <= '0;
    end else begin
      en_q   <= en_d;
      rate_q <= rate_d;
    end
  end

  always_comb begin
    irq_pull_low = 1'b0;
    if (en_q.irq_en) begin
      if (en_q.wdt_en) irq_pull_low = flag;
      else             irq_pull_low = en_q.tmr_en & wave;
    end
  end

  assign wdt_en = en_q.wdt_en;
  assign rate   = rate_q;

  p_irq_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q.irq_en |-> !irq_pull_low);
  p_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q.irq_en && en_q.wdt_en && !flag) |-> !irq_pull_low);
  p_off_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_off || wdt_off || irq_off) |=>
      (!($past(tmr_off) && en_q.tmr_en) && !($past(wdt_off) && en_q.wdt_en) &&
       !($past(irq_off) && en_q.irq_en)));
  p_rate_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rate_wr |=> $stable(rate_q));

endmodule

// File: rtl/tbase_wdog.sv
module tbase_wdog #(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned TB_W  = 7,
  parameter int unsigned WDT_W = 2,
  localparam int unsigned CODE_W = $clog2(TB_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_on,
  input  logic              tmr_off,
  input  logic              tmr_clr,
  input  logic              wdt_on,
  input  logic              wdt_off,
  input  logic              wdt_clr,
  input  logic              irq_on,
  input  logic              irq_off,
  input  logic              rate_wr,
  input  logic [CODE_W-1:0] rate_code,
  output logic              irq_pull_low
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  logic              wave, tick, flag, wdt_en;
  logic [CODE_W-1:0] rate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  tbw_divider #(.PRE_W(PRE_W), .TB_W(TB_W), .CODE_W(CODE_W)) u_div (
    .clk(clk), .rst_n(rst_n_i), .clr(tmr_clr), .code(rate),
    .wave(wave), .tick(tick));

  tbw_watchdog #(.WDT_W(WDT_W)) u_wdt (
    .clk(clk), .rst_n(rst_n_i), .tick(tick), .wdt_en(wdt_en),
    .wdt_clr(wdt_clr), .flag_clr(irq_off), .flag(flag));

  tbw_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_i),
    .tmr_on(tmr_on), .tmr_off(tmr_off), .wdt_on(wdt_on), .wdt_off(wdt_off),
    .irq_on(irq_on), .irq_off(irq_off), .rate_wr(rate_wr), .rate_code(rate_code),
    .wave(wave), .flag(flag), .wdt_en(wdt_en), .rate(rate),
    .irq_pull_low(irq_pull_low));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n_i |-> !irq_pull_low);

endmodule

// File: tb/sim_tbase_wdog.sv
module sim_tbase_wdog;
  localparam int PERIOD = 10;
  localparam int PRE_W  = 3;
  localparam int TB_W   = 7;
  localparam int CNT_W  = PRE_W + TB_W;

  logic clk = 1'b0;
  logic rst_n;
  logic tmr_on, tmr_off, tmr_clr, wdt_on, wdt_off, wdt_clr, irq_on, irq_off, rate_wr;
  logic [2:0] rate_code;
  logic irq_pull_low;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string tag = "R1";

  int m_cnt, m_stage, m_flag, m_tmr, m_wdt, m_irq, m_rate, m_hold;
  int exp_irq;

  always #(PERIOD/2) clk = ~clk;

  tbase_wdog #(.PRE_W(PRE_W), .TB_W(TB_W), .WDT_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .tmr_on(tmr_on), .tmr_off(tmr_off), .tmr_clr(tmr_clr),
    .wdt_on(wdt_on), .wdt_off(wdt_off), .wdt_clr(wdt_clr), .irq_on(irq_on),
    .irq_off(irq_off), .rate_wr(rate_wr), .rate_code(rate_code),
    .irq_pull_low(irq_pull_low));

  function automatic int wave_of(int cnt, int rate);
    return (cnt >> (CNT_W - 1 - rate)) & 1;
  endfunction

  task automatic model_step();
    int b, mask, tk, n_tmr, n_wdt, n_irq;
    if (!rst_n || m_hold > 0) begin
      m_cnt = 0; m_stage = 0; m_flag = 0; m_tmr = 0; m_wdt = 0; m_irq = 0; m_rate = 0;
      if (rst_n) m_hold--;
      return;
    end
    b = CNT_W - 1 - m_rate;
    mask = (1 << (b + 1)) - 1;
    tk = (!tmr_clr && ((m_cnt & mask) == mask)) ? 1 : 0;
    if (wdt_clr) begin
      m_stage = 0; m_flag = 0;
    end else begin
      if (irq_off) m_flag = 0;
      else if (tk && m_wdt && m_stage == 3) m_flag = 1;
      if (tk && m_wdt) m_stage = (m_stage + 1) % 4;
    end
    m_cnt = tmr_clr ? 0 : (m_cnt + 1) % (1 << CNT_W);
    n_tmr = tmr_off ? 0 : (tmr_on ? 1 : m_tmr);
    n_wdt = wdt_off ? 0 : (wdt_on ? 1 : m_wdt);
    n_irq = irq_off ? 0 : (irq_on ? 1 : m_irq);
    m_tmr = n_tmr; m_wdt = n_wdt; m_irq = n_irq;
    if (rate_wr) m_rate = rate_code;
  endtask

  task automatic check(input logic act, input int exp, input string req);
    n_chk++;
    if (act !== exp[0]) begin
      n_fail++;
      $display("FAIL %s cycle %0d irq_pull_low actual %0b expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    cyc++;
    @(negedge clk);
    if (!m_irq) exp_irq = 0;
    else if (m_wdt) exp_irq = m_flag;
    else exp_irq = m_tmr & wave_of(m_cnt, m_rate);
    check(irq_pull_low, exp_irq, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic clr_all();
    {tmr_on, tmr_off, tmr_clr, wdt_on, wdt_off, wdt_clr, irq_on, irq_off, rate_wr} = '0;
  endtask

  task automatic set_rate(input int r);
    rate_code = 3'(r); rate_wr = 1'b1; step(); rate_wr = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    clr_all(); rate_code = 3'd0; rst_n = 1'b0; m_hold = 2;
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    // R1: quiet after reset, even with strobes that are not interrupt-on
    tag = "R1"; idle(4);
    check(irq_pull_low, 0, "R1");
    tmr_on = 1'b1; step(); tmr_on = 1'b0; idle(600);
    check(irq_pull_low, 0, "R1");

    // R2/R3: time-base mode at fastest rate, then slowest, then a middle one
    tag = "R3"; irq_on = 1'b1; step(); irq_on = 1'b0;
    tag = "R10"; set_rate(7);
    tag = "R2"; tmr_clr = 1'b1; step(); tmr_clr = 1'b0;
    idle(3); check(irq_pull_low, 0, "R2");
    idle(1); check(irq_pull_low, 1, "R2");
    idle(60);
    set_rate(0); idle(2100);
    set_rate(4); idle(300);

    // R6: timer clear while the tap is high
    tag = "R6"; set_rate(7);
    tmr_clr = 1'b1; step(); tmr_clr = 1'b0; idle(5);
    tmr_clr = 1'b1; step(); tmr_clr = 1'b0;
    check(irq_pull_low, 0, "R6"); idle(40);

    // R4: exact timeout cycle at rate 7 (period 8, timeout 32)
    tag = "R4"; wdt_on = 1'b1; step(); wdt_on = 1'b0;
    tmr_clr = 1'b1; wdt_clr = 1'b1; step(); tmr_clr = 1'b0; wdt_clr = 1'b0;
    idle(31); check(irq_pull_low, 0, "R4");
    idle(1);  check(irq_pull_low, 1, "R4");
    // R6: chain restart leaves the latched flag in place
    tmr_clr = 1'b1; step(); tmr_clr = 1'b0;
    tag = "R7"; idle(100); check(irq_pull_low, 1, "R7");

    // R5: release by watchdog clear, then by interrupt off
    tag = "R5"; wdt_clr = 1'b1; step(); wdt_clr = 1'b0;
    check(irq_pull_low, 0, "R5"); idle(40);
    irq_off = 1'b1; step(); irq_off = 1'b0;
    check(irq_pull_low, 0, "R5");
    irq_on = 1'b1; step(); irq_on = 1'b0; idle(60);

    // R9: watchdog off freezes its count, R8: same-cycle on/off
    tag = "R9"; wdt_off = 1'b1; step(); wdt_off = 1'b0; idle(200);
    wdt_on = 1'b1; step(); wdt_on = 1'b0; idle(80);
    tag = "R8";
    tmr_on = 1'b1; tmr_off = 1'b1; wdt_on = 1'b1; wdt_off = 1'b1; step();
    clr_all(); idle(30); check(irq_pull_low, 0, "R8");
    irq_on = 1'b1; irq_off = 1'b1; tmr_on = 1'b1; step(); clr_all();
    idle(30); check(irq_pull_low, 0, "R8");

    // R8: pseudo-random mix of all strobes against the model
    lf = 16'hACE1;
    for (int i = 0; i < 20000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      clr_all();
      if (lf[5:0] == 6'd1)  tmr_on  = 1'b1;
      if (lf[5:0] == 6'd2)  tmr_off = 1'b1;
      if (lf[7:0] == 8'd3)  tmr_clr = 1'b1;
      if (lf[5:0] == 6'd4)  wdt_on  = 1'b1;
      if (lf[6:0] == 7'd5)  wdt_off = 1'b1;
      if (lf[7:0] == 8'd6)  wdt_clr = 1'b1;
      if (lf[5:0] == 6'd7)  irq_on  = 1'b1;
      if (lf[7:0] == 8'd8)  irq_off = 1'b1;
      if (lf[8:0] == 9'd9) begin rate_wr = 1'b1; rate_code = {1'b1, lf[10:9]}; end
      if (lf[4:0] == 5'd31) begin tmr_on = 1'b1; tmr_off = lf[11]; end
      step();
    end
    clr_all(); idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule